// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered log of register renames for one thread. Every rename that the front end performs is recorded at the young end as a four-field record: the instruction's sequence number, the architectural register that was written, the physical register just handed out, and the physical register that the architectural register pointed to before. The map table, the free list and the ready scoreboard live outside. The block only issues write strobes toward them.

The log can be drained from either end. A squash names a sequence number and unwinds from the young end. For each discarded rename, the block writes the old physical register back into the map and returns the newly assigned register to the free list. If that register lies in the range above the ordinary integer plus floating-point pool, it is also marked ready in the scoreboard. A commit names a sequence number and retires from the old end. Each retired record releases the register that its rename displaced.

Both walks move one record per clock and raise a busy flag. While busy is high, new renames are refused. A full flag tells the rename stage to stall once the configured depth is reached.

Top module: `rename_hist_buf`

## Requirements
- R1: While reset is held and directly after it, `busy`, `full`, `map_wr_valid`, `fl_ret_valid` and `sb_set_valid` are all low.
- R2: A record is stored only when `push_valid` is high, `busy` is low, `full` is low and `squash_req` is low in the same cycle. Stored records join the young end.
- R3: `full` is high exactly when DEPTH records are held. A push offered while full is dropped.
- R4: A squash starts an undo walk when the youngest record's sequence number is greater than `squash_seq`. The walk pops one record per cycle, youngest first, while its number stays greater than `squash_seq`. Each pop drives `map_wr_arch` with the record's architectural register and `map_wr_phys` with its previous physical register, and drives `fl_ret_phys` with its new physical register.
- R5: During an undo pop, `sb_set_valid` is high with `sb_set_phys` equal to the new physical register when that register is at or above PHYS_LIMIT. Below PHYS_LIMIT, `sb_set_valid` stays low.
- R6: A commit walk pops one record per cycle, oldest first, while its sequence number is at or below `commit_seq`. Each pop drives `fl_ret_phys` with the previous physical register, and `map_wr_valid` stays low.
- R7: A commit is ignored, with `busy` staying low, when the history is empty or when the oldest record's number already exceeds `commit_seq`.
- R8: `commit_req` is ignored in a cycle that also carries `squash_req`, and it is ignored while `busy` is high. A squash arriving during a commit walk completes that cycle's retirement and then switches to the undo walk.
- R9: A squash on an empty history, or one with no record younger than `squash_seq`, changes nothing and leaves `busy` low.
- R10: A walk that pops N records keeps `busy` high for N+1 cycles. Pushes offered meanwhile are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Record a rename |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_arch | input | ARCH_W | Architectural destination register |
| push_new | input | PHYS_W | Physical register just assigned |
| push_prev | input | PHYS_W | Physical register previously mapped |
| squash_req | input | 1 | Undo every rename younger than `squash_seq` |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| commit_req | input | 1 | Retire renames up to `commit_seq` |
| commit_seq | input | SEQ_W | Last committed sequence number |
| busy | output | 1 | A walk is in progress |
| full | output | 1 | History holds DEPTH records |
| map_wr_valid | output | 1 | Map-table restore strobe |
| map_wr_arch | output | ARCH_W | Architectural register to restore |
| map_wr_phys | output | PHYS_W | Physical register written back |
| fl_ret_valid | output | 1 | Free-list return strobe |
| fl_ret_phys | output | PHYS_W | Physical register returned |
| sb_set_valid | output | 1 | Scoreboard ready-set strobe |
| sb_set_phys | output | PHYS_W | Physical register marked ready |

## Verification
The bench builds the block with DEPTH=4 and PHYS_LIMIT=96, using 7-bit physical indices. The small depth lets five table pushes reach the full condition and show a dropped record. A limit of 96 inside a 128-entry index space lets one undo pop land on exactly 96 and another on 95, which covers both sides of the scoreboard boundary. With a depth of three or four, one directed sequence can run a commit walk, interrupt it with a squash, and then show that the history is empty.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  parameter int SEQ_W  = 8;
  parameter int ARCH_W = 5;
  parameter int PHYS_W = 7;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [ARCH_W-1:0] arch;
    logic [PHYS_W-1:0] newp;
    logic [PHYS_W-1:0] prevp;
  } rhb_entry_t;

  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_UNDO   = 2'd1,
    WALK_RETIRE = 2'd2
  } walk_st_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store
  import rhb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_en,
  input  rhb_entry_t push_ent,
  input  logic       pop_young,
  input  logic       pop_old,
  output rhb_entry_t young_ent,
  output rhb_entry_t old_ent,
  output logic       empty,
  output logic       full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rhb_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] young_idx;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign young_idx = ptr_dec(tail_q);
  assign young_ent = mem_q[young_idx];
  assign old_ent   = mem_q[head_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (push_en)   tail_d = ptr_inc(tail_q);
    if (pop_young) tail_d = ptr_dec(tail_q);
    if (pop_old)   head_d = ptr_inc(head_q);
    cnt_d = cnt_q + CNT_W'(push_en) - CNT_W'(pop_young) - CNT_W'(pop_old);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) mem_q[tail_q] <= push_ent;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_push_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full);
  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_young || pop_old) |-> !empty);
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_young && !push_en && !pop_old) |=> (cnt_q + 1'b1) == $past(cnt_q));
endmodule

// File: rtl/rhb_walk.sv
module rhb_walk
  import rhb_pkg::*;
#(
  parameter int PHYS_LIMIT = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              squash_req,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_req,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  rhb_entry_t        young_ent,
  input  logic [SEQ_W-1:0]  old_seq,
  input  logic [PHYS_W-1:0] old_prev,
  input  logic              empty,
  output logic              pop_young,
  output logic              pop_old,
  output logic              busy,
  output logic              map_wr_valid,
  output logic [ARCH_W-1:0] map_wr_arch,
  output logic [PHYS_W-1:0] map_wr_phys,
  output logic              fl_ret_valid,
  output logic [PHYS_W-1:0] fl_ret_phys,
  output logic              sb_set_valid,
  output logic [PHYS_W-1:0] sb_set_phys
);
  localparam logic [PHYS_W-1:0] LIMIT = PHYS_W'(PHYS_LIMIT);

  walk_st_e         state_q, state_d;
  logic [SEQ_W-1:0] bound_q, bound_d;
  logic             undo_hit, retire_hit, squash_go, commit_go;

  assign undo_hit   = (state_q == WALK_UNDO) && !empty && (young_ent.seq > bound_q);
  assign retire_hit = (state_q == WALK_RETIRE) && !empty && (old_seq <= bound_q);
  assign squash_go  = squash_req && !empty && (young_ent.seq > squash_seq);
  assign commit_go  = commit_req && !squash_req && !empty && (old_seq <= commit_seq);

  always_comb begin
    state_d = state_q;
    bound_d = bound_q;
    unique case (state_q)
      WALK_IDLE: begin
        if (squash_go) begin
          state_d = WALK_UNDO;
          bound_d = squash_seq;
        end else if (commit_go) begin
          state_d = WALK_RETIRE;
          bound_d = commit_seq;
        end
      end
      WALK_RETIRE: begin
        if (squash_go) begin
          state_d = WALK_UNDO;
          bound_d = squash_seq;
        end else if (squash_req || !retire_hit) begin
          state_d = WALK_IDLE;
        end
      end
      WALK_UNDO: begin
        if (!undo_hit) state_d = WALK_IDLE;
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      bound_q <= '0;
    end else begin
      state_q <= state_d;
      bound_q <= bound_d;
    end
  end

  assign busy         = (state_q != WALK_IDLE);
  assign pop_young    = undo_hit;
  assign pop_old      = retire_hit;
  assign map_wr_valid = undo_hit;
  assign map_wr_arch  = young_ent.arch;
  assign map_wr_phys  = young_ent.prevp;
  assign fl_ret_valid = undo_hit || retire_hit;
  assign fl_ret_phys  = undo_hit ? young_ent.newp : old_prev;
  assign sb_set_valid = undo_hit && (young_ent.newp >= LIMIT);
  assign sb_set_phys  = young_ent.newp;

  assert_undo_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_valid |-> (fl_ret_valid && fl_ret_phys == sb_set_phys));
  assert_sb_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sb_set_valid |-> (map_wr_valid && sb_set_phys >= LIMIT));
  assert_retire_no_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_old |-> !map_wr_valid);
  assert_one_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_young, pop_old}));
  assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ret_valid |-> busy);
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf
  import rhb_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int PHYS_LIMIT = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ARCH_W-1:0] push_arch,
  input  logic [PHYS_W-1:0] push_new,
  input  logic [PHYS_W-1:0] push_prev,
  input  logic              squash_req,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              commit_req,
  input  logic [SEQ_W-1:0]  commit_seq,
  output logic              busy,
  output logic              full,
  output logic              map_wr_valid,
  output logic [ARCH_W-1:0] map_wr_arch,
  output logic [PHYS_W-1:0] map_wr_phys,
  output logic              fl_ret_valid,
  output logic [PHYS_W-1:0] fl_ret_phys,
  output logic              sb_set_valid,
  output logic [PHYS_W-1:0] sb_set_phys
);
  rhb_entry_t push_ent, young_ent, old_ent;
  logic       push_en, pop_young, pop_old, empty;

  assign push_ent = '{seq: push_seq, arch: push_arch, newp: push_new, prevp: push_prev};
  assign push_en  = push_valid && !busy && !full && !squash_req;

  rhb_store #(.DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_ent  (push_ent),
    .pop_young (pop_young),
    .pop_old   (pop_old),
    .young_ent (young_ent),
    .old_ent   (old_ent),
    .empty     (empty),
    .full      (full)
  );

  rhb_walk #(.PHYS_LIMIT(PHYS_LIMIT)) walk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .squash_req   (squash_req),
    .squash_seq   (squash_seq),
    .commit_req   (commit_req),
    .commit_seq   (commit_seq),
    .young_ent    (young_ent),
    .old_seq      (old_ent.seq),
    .old_prev     (old_ent.prevp),
    .empty        (empty),
    .pop_young    (pop_young),
    .pop_old      (pop_old),
    .busy         (busy),
    .map_wr_valid (map_wr_valid),
    .map_wr_arch  (map_wr_arch),
    .map_wr_phys  (map_wr_phys),
    .fl_ret_valid (fl_ret_valid),
    .fl_ret_phys  (fl_ret_phys),
    .sb_set_valid (sb_set_valid),
    .sb_set_phys  (sb_set_phys)
  );

  assert_walk_blocks_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_young || pop_old) |-> !push_en);
endmodule

// File: tb/rename_hist_buf_tb_top.sv
`timescale 1ns/1ps
module rename_hist_buf_tb_top;
  import rhb_pkg::*;
  localparam int DEPTH = 4;
  localparam int PHYS_LIMIT = 96;

  // row: seq[27:20] arch[19:15] new[14:8] prev[7:1] expected_full[0]
  localparam logic [27:0] PUSH_TBL [5] = '{
    {8'd10, 5'd1, 7'd40,  7'd30, 1'b0},
    {8'd11, 5'd2, 7'd41,  7'd31, 1'b0},
    {8'd12, 5'd3, 7'd50,  7'd21, 1'b0},
    {8'd13, 5'd4, 7'd100, 7'd20, 1'b1},
    {8'd14, 5'd5, 7'd60,  7'd22, 1'b1}
  };

  logic clk, rst_n;
  logic push_valid, squash_req, commit_req;
  logic [SEQ_W-1:0] push_seq, squash_seq, commit_seq;
  logic [ARCH_W-1:0] push_arch, map_wr_arch;
  logic [PHYS_W-1:0] push_new, push_prev, map_wr_phys, fl_ret_phys, sb_set_phys;
  logic busy, full, map_wr_valid, fl_ret_valid, sb_set_valid;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  rename_hist_buf #(.DEPTH(DEPTH), .PHYS_LIMIT(PHYS_LIMIT)) dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input int s, input int a, input int n, input int p);
    push_seq = SEQ_W'(s); push_arch = ARCH_W'(a);
    push_new = PHYS_W'(n); push_prev = PHYS_W'(p);
    push_valid = 1'b1; tick(); push_valid = 1'b0;
  endtask

  task automatic undo_pop(input string tag, input int a, input int pv, input int nw, input int sb);
    chk({tag, " map valid"}, int'(map_wr_valid), 1);
    chk({tag, " map arch"}, int'(map_wr_arch), a);
    chk({tag, " map phys"}, int'(map_wr_phys), pv);
    chk({tag, " free phys"}, int'(fl_ret_phys), nw);
    chk({tag, " sb valid"}, int'(sb_set_valid), sb);
    if (sb != 0) chk({tag, " sb phys"}, int'(sb_set_phys), nw);
  endtask

  task automatic retire_pop(input string tag, input int pv);
    chk({tag, " free valid"}, int'(fl_ret_valid), 1);
    chk({tag, " free phys"}, int'(fl_ret_phys), pv);
    chk({tag, " no map"}, int'(map_wr_valid), 0);
  endtask

  task automatic req(input bit sq, input int sqs, input bit cm, input int cms);
    squash_req = sq; squash_seq = SEQ_W'(sqs);
    commit_req = cm; commit_seq = SEQ_W'(cms);
    tick();
    squash_req = 1'b0; commit_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; push_valid = 0; squash_req = 0; commit_req = 0;
    push_seq = '0; push_arch = '0; push_new = '0; push_prev = '0;
    squash_seq = '0; commit_seq = '0;
    repeat (3) tick();
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 full in reset", int'(full), 0);
    chk("R1 strobes in reset", int'({map_wr_valid, fl_ret_valid, sb_set_valid}), 0);
    rst_n = 1'b1; tick();
    chk("R1 busy after reset", int'(busy), 0);

    for (int i = 0; i < 5; i++) begin
      push(int'(PUSH_TBL[i][27:20]), int'(PUSH_TBL[i][19:15]),
           int'(PUSH_TBL[i][14:8]), int'(PUSH_TBL[i][7:1]));
      chk("R3 full after table push", int'(full), int'(PUSH_TBL[i][0]));
      chk("R2 idle after push", int'(busy), 0);
    end

    // undo walk: seq 13 then 12; seq 14 was dropped while full
    req(1'b1, 11, 1'b0, 0);
    push_seq = 8'd99; push_arch = 5'd9; push_new = 7'd9; push_prev = 7'd9;
    push_valid = 1'b1;
    undo_pop("R4 R5 undo 1", 4, 20, 100, 1);
    chk("R3 R4 dropped seq14 not popped", int'(map_wr_arch), 4);
    tick(); push_valid = 1'b0;
    commit_req = 1'b1; commit_seq = 8'd255;
    undo_pop("R4 R5 undo 2", 3, 21, 50, 0);
    tick(); commit_req = 1'b0;
    chk("R10 busy on last walk cycle", int'(busy), 1);
    chk("R4 no strobe at stop", int'(fl_ret_valid), 0);
    tick();
    chk("R10 busy ends after N+1", int'(busy), 0);
    chk("R8 commit during undo ignored", int'(fl_ret_valid), 0);
    chk("R3 full cleared", int'(full), 0);

    req(1'b1, 20, 1'b0, 0);
    chk("R9 squash with no younger", int'(busy), 0);
    req(1'b0, 0, 1'b1, 9);
    chk("R7 commit older than oldest", int'(busy), 0);
    req(1'b1, 200, 1'b1, 255);
    chk("R8 commit with squash ignored", int'(busy), 0);

    req(1'b0, 0, 1'b1, 255);
    retire_pop("R6 retire 1", 30);
    tick();
    retire_pop("R6 retire 2 (R10 push during busy dropped)", 31);
    tick();
    chk("R6 busy at stop", int'(busy), 1);
    chk("R6 no strobe at stop", int'(fl_ret_valid), 0);
    tick();
    chk("R6 walk done", int'(busy), 0);

    req(1'b0, 0, 1'b1, 255);
    chk("R7 commit on empty", int'(busy), 0);
    req(1'b1, 0, 1'b0, 0);
    chk("R9 squash on empty", int'(busy), 0);

    push_seq = 8'd40; push_arch = 5'd1; push_new = 7'd1; push_prev = 7'd1;
    push_valid = 1'b1; squash_req = 1'b1; squash_seq = 8'd0;
    tick(); push_valid = 1'b0; squash_req = 1'b0;
    req(1'b0, 0, 1'b1, 255);
    chk("R2 push with squash dropped", int'(busy), 0);

    push(50, 6, 70, 33);
    push(51, 7, 95, 34);
    push(52, 8, 96, 35);
    req(1'b0, 0, 1'b1, 255);
    retire_pop("R6 retire before squash", 33);
    req(1'b1, 50, 1'b0, 0);
    undo_pop("R8 R5 undo after preempt at limit", 8, 35, 96, 1);
    tick();
    undo_pop("R8 R5 undo below limit", 7, 34, 95, 0);
    tick();
    chk("R8 busy at stop", int'(busy), 1);
    tick();
    chk("R8 walk done", int'(busy), 0);
    req(1'b0, 0, 1'b1, 255);
    chk("R8 history empty after preempt", int'(busy), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule